// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the operand bytes of an 8-bit processor instruction into the 16-bit address that the instruction works on. A sequencer presents the addressing mode, the one or two bytes that follow the opcode, the two index registers, the address of the next instruction and, for the pointer-based modes, the two pointer bytes it has already read from memory. One clock later the block returns the effective address. For the pointer-based modes it also returns the addresses where the pointer's low and high bytes sit, so the sequencer can fetch them.

The sequencer uses the block twice for a pointer-based mode. It first presents the operands and reads back the two pointer-byte addresses. It fetches those bytes, then presents everything again with the fetched bytes on the pointer inputs, and reads the final target. The block does no bus sequencing and holds no memory. It registers its results once per valid input and keeps them until the next valid input arrives.

Top module: `op_ea_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid`, `eff_addr`, `ptr_lo_addr`, `ptr_hi_addr`, `ptr_fetch` and `no_addr` are all zero.
- R2: When `in_valid` is high at a rising edge, the results for that input appear after that same edge, and `out_valid` is high for exactly that cycle. While `in_valid` is low, every result output keeps its last value, whatever happens on the other inputs.
- R3: Mode 1 (zero page) gives `eff_addr` = {0x00, `opnd_lo`} and `ptr_fetch` = 0.
- R4: Modes 2 and 3 (zero page indexed by X or by Y) add the selected index to `opnd_lo` modulo 256, and the high byte is 0x00. For example, 0x80 + 0xFE gives 0x007E.
- R5: Mode 4 (absolute) gives {`opnd_hi`, `opnd_lo`}. Modes 5 and 6 add the unsigned X or Y value to that 16-bit base, with carry into the high byte and wrap at 0xFFFF.
- R6: Mode 7 (relative) adds the sign-extended `opnd_lo` to `next_pc` modulo 2^16. A displacement of 0xFE gives `next_pc` - 2, so the target stays within -128..+127 of `next_pc`.
- R7: Mode 8 (indirect) gives `ptr_lo_addr` = {`opnd_hi`, `opnd_lo`} and `ptr_hi_addr` = that value + 1 over the full 16 bits, with `ptr_fetch` = 1. The effective address is {`ptr_hi_data`, `ptr_lo_data`}.
- R8: Mode 9 (pre-indexed indirect) gives `ptr_lo_addr` = {0x00, (`opnd_lo` + X) mod 256} and `ptr_hi_addr` = {0x00, (`opnd_lo` + X + 1) mod 256}, with `ptr_fetch` = 1. The effective address is {`ptr_hi_data`, `ptr_lo_data`}.
- R9: Mode 10 (post-indexed indirect) gives `ptr_lo_addr` = {0x00, `opnd_lo`} and `ptr_hi_addr` = {0x00, (`opnd_lo` + 1) mod 256}, with `ptr_fetch` = 1. The effective address is {`ptr_hi_data`, `ptr_lo_data`} + unsigned Y, with carry into the high byte.
- R10: Mode 0 (immediate, implied or accumulator) and the unused codes 11 to 15 set `no_addr` = 1, with `eff_addr` = 0, `ptr_fetch` = 0 and both pointer addresses 0. Every other mode gives `no_addr` = 0. In every mode other than 8, 9 and 10, `ptr_fetch` = 0 and both pointer addresses are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| mode | input | 4 | Addressing mode code (0 to 10, others treated as no address) |
| opnd_lo | input | 8 | First operand byte after the opcode |
| opnd_hi | input | 8 | Second operand byte after the opcode |
| x_reg | input | 8 | X index register value |
| y_reg | input | 8 | Y index register value |
| next_pc | input | 16 | Address of the instruction that follows |
| ptr_lo_data | input | 8 | Pointer low byte already fetched |
| ptr_hi_data | input | 8 | Pointer high byte already fetched |
| out_valid | output | 1 | Results updated this cycle |
| eff_addr | output | 16 | Effective address |
| ptr_lo_addr | output | 16 | Address of the pointer low byte |
| ptr_hi_addr | output | 16 | Address of the pointer high byte |
| ptr_fetch | output | 1 | Mode needs a pointer fetch |
| no_addr | output | 1 | Mode needs no effective address |

## Verification
Two functions can meet in a single post-indexed request: the high-byte address of the pointer must wrap inside page zero, and adding Y to the fetched pointer must carry into the high byte of the target. The bench provokes both at once with `opnd_lo` = 0xFF, Y = 0x01 and a fetched pointer of 0x12FF. It expects pointer addresses 0x00FF and 0x0000 and a target of 0x1300. The pre-indexed mode gets the same treatment with an operand-plus-X sum of 0xFF, so that its high-byte pointer address wraps to 0x0000 in the same result as the low-byte fetch address.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_NONE  = 4'd0,
    AM_ZP    = 4'd1,
    AM_ZPX   = 4'd2,
    AM_ZPY   = 4'd3,
    AM_ABS   = 4'd4,
    AM_ABSX  = 4'd5,
    AM_ABSY  = 4'd6,
    AM_REL   = 4'd7,
    AM_IND   = 4'd8,
    AM_PREX  = 4'd9,
    AM_POSTY = 4'd10
  } am_e;
endpackage

// File: rtl/eag_index_add.sv
// Adds an unsigned index to a base address. WRAP=1 keeps the sum inside
// page zero (carry dropped); WRAP=0 carries into the high byte.
module eag_index_add #(
  parameter int DATA_W = 8,
  parameter bit WRAP   = 1'b0
) (
  input  logic [2*DATA_W-1:0] base,
  input  logic [DATA_W-1:0]   idx,
  output logic [2*DATA_W-1:0] sum
);
  localparam int AW = 2 * DATA_W;

  generate
    if (WRAP) begin : g_page_wrap
      logic [DATA_W-1:0] low_sum;
      logic              unused_base_hi;
      assign unused_base_hi = ^base[AW-1:DATA_W];
      assign low_sum = base[DATA_W-1:0] + idx;
      assign sum     = {{DATA_W{1'b0}}, low_sum};
    end else begin : g_full_carry
      assign sum = base + {{DATA_W{1'b0}}, idx};
    end
  endgenerate
endmodule

// File: rtl/eag_rel_target.sv
// Branch target: next-instruction address plus sign-extended displacement.
module eag_rel_target #(
  parameter int DATA_W = 8
) (
  input  logic [2*DATA_W-1:0] pc_next,
  input  logic [DATA_W-1:0]   disp,
  output logic [2*DATA_W-1:0] target
);
  assign target = pc_next + {{DATA_W{disp[DATA_W-1]}}, disp};
endmodule

// File: rtl/eag_ptr_locate.sv
// Locates the two bytes of a pointer for the indirect modes.
module eag_ptr_locate
  import eag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  am_e                 mode,
  input  logic [DATA_W-1:0]   op_lo,
  input  logic [DATA_W-1:0]   op_hi,
  input  logic [DATA_W-1:0]   idx_x,
  output logic [2*DATA_W-1:0] lo_addr,
  output logic [2*DATA_W-1:0] hi_addr,
  output logic                used
);
  localparam int AW = 2 * DATA_W;

  logic [DATA_W-1:0] zp_slot;
  logic [AW-1:0]     abs_ptr;

  always_comb begin
    lo_addr = '0;
    hi_addr = '0;
    used    = 1'b0;
    zp_slot = '0;
    abs_ptr = '0;
    case (mode)
      AM_IND: begin
        abs_ptr = {op_hi, op_lo};
        lo_addr = abs_ptr;
        hi_addr = abs_ptr + AW'(1);
        used    = 1'b1;
      end
      AM_PREX: begin
        zp_slot = op_lo + idx_x;
        lo_addr = {{DATA_W{1'b0}}, zp_slot};
        hi_addr = {{DATA_W{1'b0}}, DATA_W'(zp_slot + DATA_W'(1))};
        used    = 1'b1;
      end
      AM_POSTY: begin
        zp_slot = op_lo;
        lo_addr = {{DATA_W{1'b0}}, zp_slot};
        hi_addr = {{DATA_W{1'b0}}, DATA_W'(zp_slot + DATA_W'(1))};
        used    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/op_ea_gen.sv
module op_ea_gen
  import eag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [MODE_W-1:0]     mode,
  input  logic [DATA_W-1:0]     opnd_lo,
  input  logic [DATA_W-1:0]     opnd_hi,
  input  logic [DATA_W-1:0]     x_reg,
  input  logic [DATA_W-1:0]     y_reg,
  input  logic [2*DATA_W-1:0]   next_pc,
  input  logic [DATA_W-1:0]     ptr_lo_data,
  input  logic [DATA_W-1:0]     ptr_hi_data,
  output logic                  out_valid,
  output logic [2*DATA_W-1:0]   eff_addr,
  output logic [2*DATA_W-1:0]   ptr_lo_addr,
  output logic [2*DATA_W-1:0]   ptr_hi_addr,
  output logic                  ptr_fetch,
  output logic                  no_addr
);
  localparam int AW = 2 * DATA_W;

  am_e mode_e;
  assign mode_e = am_e'(mode);

  // Index selection: Y for the ,Y forms, X otherwise
  logic [DATA_W-1:0] zp_idx, abs_idx;
  assign zp_idx  = (mode_e == AM_ZPY)  ? y_reg : x_reg;
  assign abs_idx = (mode_e == AM_ABSY) ? y_reg : x_reg;

  logic [AW-1:0] zp_sum, abs_sum, post_sum, rel_sum;
  logic [AW-1:0] loc_lo, loc_hi;
  logic          loc_used;

  eag_index_add #(.DATA_W(DATA_W), .WRAP(1'b1)) u_zp_add (
    .base ({{DATA_W{1'b0}}, opnd_lo}),
    .idx  (zp_idx),
    .sum  (zp_sum)
  );

  eag_index_add #(.DATA_W(DATA_W), .WRAP(1'b0)) u_abs_add (
    .base ({opnd_hi, opnd_lo}),
    .idx  (abs_idx),
    .sum  (abs_sum)
  );

  eag_index_add #(.DATA_W(DATA_W), .WRAP(1'b0)) u_post_add (
    .base ({ptr_hi_data, ptr_lo_data}),
    .idx  (y_reg),
    .sum  (post_sum)
  );

  eag_rel_target #(.DATA_W(DATA_W)) u_rel (
    .pc_next (next_pc),
    .disp    (opnd_lo),
    .target  (rel_sum)
  );

  eag_ptr_locate #(.DATA_W(DATA_W)) u_ptr (
    .mode    (mode_e),
    .op_lo   (opnd_lo),
    .op_hi   (opnd_hi),
    .idx_x   (x_reg),
    .lo_addr (loc_lo),
    .hi_addr (loc_hi),
    .used    (loc_used)
  );

  logic [AW-1:0] ea_d;
  logic          none_d;

  always_comb begin
    ea_d   = '0;
    none_d = 1'b0;
    case (mode_e)
      AM_ZP:              ea_d = {{DATA_W{1'b0}}, opnd_lo};
      AM_ZPX, AM_ZPY:     ea_d = zp_sum;
      AM_ABS:             ea_d = {opnd_hi, opnd_lo};
      AM_ABSX, AM_ABSY:   ea_d = abs_sum;
      AM_REL:             ea_d = rel_sum;
      AM_IND, AM_PREX:    ea_d = {ptr_hi_data, ptr_lo_data};
      AM_POSTY:           ea_d = post_sum;
      default:            none_d = 1'b1;
    endcase
  end

  // Registered result stage
  am_e  mode_q;
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      out_valid   <= 1'b0;
      eff_addr    <= '0;
      ptr_lo_addr <= '0;
      ptr_hi_addr <= '0;
      ptr_fetch   <= 1'b0;
      no_addr     <= 1'b0;
      mode_q      <= AM_NONE;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        eff_addr    <= ea_d;
        ptr_lo_addr <= loc_lo;
        ptr_hi_addr <= loc_hi;
        ptr_fetch   <= loc_used;
        no_addr     <= none_d;
        mode_q      <= mode_e;
      end
    end
  end

  // Assertions
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && !$past(in_valid)) |-> ($stable(eff_addr) && $stable(ptr_lo_addr)
                                      && $stable(ptr_hi_addr) && $stable(no_addr)));

  assert_zp_page_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY))
      |-> (eff_addr[AW-1:DATA_W] == '0));

  assert_rel_reach_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q == AM_REL)
      |-> (AW'(eff_addr - $past(next_pc) + AW'(128)) < AW'(256)));

  assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (mode_q == AM_PREX || mode_q == AM_POSTY))
      |-> (ptr_hi_addr[AW-1:DATA_W] == '0 && ptr_lo_addr[AW-1:DATA_W] == '0
           && ptr_hi_addr[DATA_W-1:0] == DATA_W'(ptr_lo_addr[DATA_W-1:0] + DATA_W'(1))));

  assert_no_addr_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && no_addr) |-> (eff_addr == '0 && !ptr_fetch && ptr_lo_addr == '0));

  assert_fetch_excl_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(ptr_fetch && no_addr));
endmodule

// File: tb/tb_op_ea_gen.sv
`timescale 1ns/1ps
module tb_op_ea_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  mode;
  logic [7:0]  opnd_lo, opnd_hi, x_reg, y_reg, ptr_lo_data, ptr_hi_data;
  logic [15:0] next_pc;
  logic        out_valid, ptr_fetch, no_addr;
  logic [15:0] eff_addr, ptr_lo_addr, ptr_hi_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  op_ea_gen dut (
    .clk, .rst, .in_valid, .mode, .opnd_lo, .opnd_hi, .x_reg, .y_reg,
    .next_pc, .ptr_lo_data, .ptr_hi_data, .out_valid, .eff_addr,
    .ptr_lo_addr, .ptr_hi_addr, .ptr_fetch, .no_addr
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc,
                       input logic [7:0] pl, input logic [7:0] ph);
    @(negedge clk);
    mode = m; opnd_lo = lo; opnd_hi = hi; x_reg = x; y_reg = y;
    next_pc = pc; ptr_lo_data = pl; ptr_hi_data = ph; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; mode = 4'd1; opnd_lo = 8'hAA; opnd_hi = 8'h55;
    x_reg = 8'h11; y_reg = 8'h22; next_pc = 16'h1234; ptr_lo_data = 8'h01; ptr_hi_data = 8'h02;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {15'd0, out_valid}, 16'd0);
    chk("R1 eff_addr in reset", eff_addr, 16'h0000);
    chk("R1 ptr_hi_addr in reset", ptr_hi_addr, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 flags after reset", {14'd0, ptr_fetch, no_addr}, 16'd0);
    chk("R1 ptr_lo_addr after reset", ptr_lo_addr, 16'h0000);
  endtask

  task automatic t_zero_page;
    drive(4'd1, 8'h37, 8'hC3, 8'h10, 8'h20, 16'h4000, 8'h00, 8'h00);
    chk("R3 zero page ea", eff_addr, 16'h0037);
    chk("R3 zero page no fetch", {15'd0, ptr_fetch}, 16'd0);
    chk("R10 zero page no_addr low", {15'd0, no_addr}, 16'd0);
    chk("R10 zero page ptr addr", ptr_lo_addr, 16'h0000);
  endtask

  task automatic t_zp_indexed;
    drive(4'd2, 8'h80, 8'h77, 8'hFE, 8'h03, 16'h0000, 8'h00, 8'h00);
    chk("R4 zp,X wrap", eff_addr, 16'h007E);
    drive(4'd3, 8'h10, 8'h99, 8'h99, 8'h05, 16'h0000, 8'h00, 8'h00);
    chk("R4 zp,Y selects Y", eff_addr, 16'h0015);
    drive(4'd3, 8'hFF, 8'h12, 8'h00, 8'h01, 16'h0000, 8'h00, 8'h00);
    chk("R4 zp,Y wrap to 00", eff_addr, 16'h0000);
  endtask

  task automatic t_absolute;
    drive(4'd4, 8'h00, 8'h20, 8'h33, 8'h44, 16'h0000, 8'h00, 8'h00);
    chk("R5 absolute", eff_addr, 16'h2000);
    drive(4'd5, 8'hF0, 8'h12, 8'h20, 8'h01, 16'h0000, 8'h00, 8'h00);
    chk("R5 abs,X carry", eff_addr, 16'h1310);
    drive(4'd6, 8'h00, 8'h30, 8'h07, 8'h45, 16'h0000, 8'h00, 8'h00);
    chk("R5 abs,Y", eff_addr, 16'h3045);
    drive(4'd6, 8'hFF, 8'hFF, 8'h00, 8'h01, 16'h0000, 8'h00, 8'h00);
    chk("R5 abs,Y top wrap", eff_addr, 16'h0000);
  endtask

  task automatic t_relative;
    drive(4'd7, 8'hFE, 8'h00, 8'h00, 8'h00, 16'h1002, 8'h00, 8'h00);
    chk("R6 rel self", eff_addr, 16'h1000);
    drive(4'd7, 8'h7F, 8'h00, 8'h00, 8'h00, 16'h2000, 8'h00, 8'h00);
    chk("R6 rel +127", eff_addr, 16'h207F);
    drive(4'd7, 8'h80, 8'h00, 8'h00, 8'h00, 16'h2000, 8'h00, 8'h00);
    chk("R6 rel -128", eff_addr, 16'h1F80);
    drive(4'd7, 8'h80, 8'h00, 8'h00, 8'h00, 16'h0010, 8'h00, 8'h00);
    chk("R6 rel wrap below 0", eff_addr, 16'hFF90);
  endtask

  task automatic t_indirect;
    drive(4'd8, 8'h00, 8'h02, 8'h55, 8'h66, 16'h0000, 8'h34, 8'h12);
    chk("R7 ind ptr lo", ptr_lo_addr, 16'h0200);
    chk("R7 ind ptr hi", ptr_hi_addr, 16'h0201);
    chk("R7 ind ea", eff_addr, 16'h1234);
    chk("R7 ind fetch", {15'd0, ptr_fetch}, 16'd1);
    drive(4'd8, 8'hFF, 8'h02, 8'h00, 8'h00, 16'h0000, 8'h00, 8'h80);
    chk("R7 ind ptr hi crosses page", ptr_hi_addr, 16'h0300);
  endtask

  task automatic t_pre_indexed;
    drive(4'd9, 8'h50, 8'hAB, 8'h20, 8'h99, 16'h0000, 8'h34, 8'h12);
    chk("R8 pre ptr lo", ptr_lo_addr, 16'h0070);
    chk("R8 pre ptr hi", ptr_hi_addr, 16'h0071);
    chk("R8 pre ea", eff_addr, 16'h1234);
    drive(4'd9, 8'hF0, 8'h00, 8'h0F, 8'h00, 16'h0000, 8'hCD, 8'hAB);
    chk("R8 pre ptr lo edge", ptr_lo_addr, 16'h00FF);
    chk("R8 pre ptr hi wrap", ptr_hi_addr, 16'h0000);
    chk("R8 pre ea edge", eff_addr, 16'hABCD);
  endtask

  task automatic t_post_indexed;
    drive(4'd10, 8'h2A, 8'hEE, 8'h77, 8'h45, 16'h0000, 8'h00, 8'h40);
    chk("R9 post ptr lo", ptr_lo_addr, 16'h002A);
    chk("R9 post ptr hi", ptr_hi_addr, 16'h002B);
    chk("R9 post ea", eff_addr, 16'h4045);
    drive(4'd10, 8'hFF, 8'h00, 8'h00, 8'h01, 16'h0000, 8'hFF, 8'h12);
    chk("R9 post ptr lo edge", ptr_lo_addr, 16'h00FF);
    chk("R9 post ptr hi wrap", ptr_hi_addr, 16'h0000);
    chk("R9 post ea carry", eff_addr, 16'h1300);
    chk("R9 post fetch", {15'd0, ptr_fetch}, 16'd1);
  endtask

  task automatic t_no_addr;
    drive(4'd0, 8'h12, 8'h34, 8'h56, 8'h78, 16'h9ABC, 8'h11, 8'h22);
    chk("R10 mode0 no_addr", {15'd0, no_addr}, 16'd1);
    chk("R10 mode0 ea zero", eff_addr, 16'h0000);
    chk("R10 mode0 no fetch", {15'd0, ptr_fetch}, 16'd0);
    drive(4'd15, 8'h12, 8'h34, 8'h56, 8'h78, 16'h9ABC, 8'h11, 8'h22);
    chk("R10 code15 no_addr", {15'd0, no_addr}, 16'd1);
    chk("R10 code15 ptr hi zero", ptr_hi_addr, 16'h0000);
    drive(4'd5, 8'h00, 8'h10, 8'h01, 8'h00, 16'h0000, 8'h00, 8'h00);
    chk("R10 abs,X ptr lo zero", ptr_lo_addr, 16'h0000);
    chk("R10 abs,X no fetch", {15'd0, ptr_fetch}, 16'd0);
  endtask

  task automatic t_hold;
    drive(4'd1, 8'h42, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h00, 8'h00);
    chk("R2 out_valid pulse", {15'd0, out_valid}, 16'd1);
    mode = 4'd8; opnd_lo = 8'h00; opnd_hi = 8'h55; ptr_lo_data = 8'h99; ptr_hi_data = 8'h88;
    @(negedge clk);
    chk("R2 out_valid drops", {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    chk("R2 ea held while idle", eff_addr, 16'h0042);
    chk("R2 ptr addr held while idle", ptr_lo_addr, 16'h0000);
    chk("R2 fetch held while idle", {15'd0, ptr_fetch}, 16'd0);
  endtask

  initial begin
    t_reset();
    t_zero_page();
    t_zp_indexed();
    t_absolute();
    t_relative();
    t_indirect();
    t_pre_indexed();
    t_post_indexed();
    t_no_addr();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule